// File: doc/BRIEF.md
# Open-Row DRAM Bank Command Sequencer

This block sits on the controller side of a synchronous DRAM channel. It turns read requests of the form (bank, row, column) into a stream of DRAM commands: precharge, activate and read. For every bank it records whether a row is currently open and which row that is. Each incoming request is sorted into one of three cases. A hit goes to the row that is already open and needs only the column read. An empty access goes to an idle bank and needs an activate and then the read. A conflict goes to a bank that has a different row open, so that row is closed, the new row is opened, and then the read is issued.

Requests use a valid/ready handshake and are served strictly in arrival order, one at a time. Two programmable cycle counts set the spacing between commands. One is the gap from precharge to activate. The other is the gap from activate to read. Each command leaves on a two-bit code, and its bank, row and column fields appear alongside it. The classification of each request shows on a status output in the cycle the request is accepted.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset every bank is idle with no open row. `req_ready_o` is 1, `cmd_o` is NOP and every command field is 0. The first request to any bank after reset is classified as empty.
- R2: A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both 1. In that same cycle `kind_valid_o` is 1 and `kind_o` gives the class: 1 = hit, 2 = empty, 3 = conflict. `kind_o` is 0 whenever no request is being accepted. `req_ready_o` returns to 1 in the cycle after the read is issued.
- R3: A hit issues READ in the cycle after acceptance, with no precharge and no activate.
- R4: An empty access issues ACTIVATE in the cycle after acceptance. READ follows exactly `t_rcd_i` cycles after the ACTIVATE.
- R5: A conflict issues PRECHARGE in the cycle after acceptance. ACTIVATE follows exactly `t_rp_i` cycles after the PRECHARGE, and READ follows exactly `t_rcd_i` cycles after the ACTIVATE.
- R6: A gap count of 0 on `t_rp_i` or `t_rcd_i` behaves as 1. Each gap count is sampled in the cycle that starts its gap: `t_rp_i` when PRECHARGE is issued, `t_rcd_i` when ACTIVATE is issued.
- R7: Command codes on `cmd_o` are NOP = 0, ACTIVATE = 1, READ = 2 and PRECHARGE = 3, and at most one command is issued per cycle. `cmd_bank_o` carries the request's bank on every non-NOP command. `cmd_row_o` carries the row only with ACTIVATE and `cmd_col_o` carries the column only with READ. Every field is 0 otherwise.
- R8: Each bank keeps its own open-row state. Activity in other banks does not change whether a bank is classified as hit, empty or conflict.
- R9: While a request is in progress, `req_ready_o` is 0. A request presented during that time is not taken and produces no commands and no classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer can take a request |
| req_bank_i | input | 3 | Request bank |
| req_row_i | input | 14 | Request row |
| req_col_i | input | 10 | Request column |
| t_rp_i | input | 4 | Precharge-to-activate gap in cycles (0 behaves as 1) |
| t_rcd_i | input | 4 | Activate-to-read gap in cycles (0 behaves as 1) |
| cmd_o | output | 2 | Command: 0 NOP, 1 ACTIVATE, 2 READ, 3 PRECHARGE |
| cmd_bank_o | output | 3 | Bank of the current command |
| cmd_row_o | output | 14 | Row, valid with ACTIVATE |
| cmd_col_o | output | 10 | Column, valid with READ |
| kind_valid_o | output | 1 | A request is being accepted this cycle |
| kind_o | output | 2 | Class of the accepted request: 1 hit, 2 empty, 3 conflict |

## Verification
The assertions check several rules on every cycle against the per-bank state. ACTIVATE is only ever issued to an idle bank. PRECHARGE is only ever issued to an open bank. READ is only ever issued to the row that is currently open. The first command after acceptance must match the request's class, and the gap counter can never wrap. Other behaviour only the bench's scenarios can show. These are the exact cycle counts between commands for chosen gap values, the clamping of a zero gap, the field values carried on each command, and the independence of banks across mixed traffic. They also include the loss of all open rows at a reset that arrives mid-run.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    KIND_NONE     = 2'd0,
    KIND_HIT      = 2'd1,
    KIND_EMPTY    = 2'd2,
    KIND_CONFLICT = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PRE  = 2'd1,
    S_WACT = 2'd2,
    S_WRD  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dbs_bank_table.sv
module dbs_bank_table #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] lk_bank_i,
  output logic              lk_open_o,
  output logic [ROW_W-1:0]  lk_row_o,
  input  logic              act_i,
  input  logic              pre_i,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] upd_bank_i,
  input  logic [ROW_W-1:0]  upd_row_i
);
  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit_upd;
    assign hit_upd = (upd_bank_i == BANK_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[g] <= 1'b0;
        row_q[g]  <= '0;
      end else if (hit_upd && act_i) begin
        open_q[g] <= 1'b1;
        row_q[g]  <= upd_row_i;
      end else if (hit_upd && pre_i) begin
        open_q[g] <= 1'b0;
      end
    end
  end

  assign lk_open_o = open_q[lk_bank_i];
  assign lk_row_o  = row_q[lk_bank_i];

  AST_ACT_IDLE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_q[upd_bank_i]); // R4
  AST_PRE_OPEN_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> open_q[upd_bank_i]); // R5
  AST_RD_OPEN_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (open_q[upd_bank_i] && row_q[upd_bank_i] == upd_row_i)); // R3
  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({act_i, pre_i, rd_i}) <= 1); // R7
endmodule

// File: rtl/dbs_gap_timer.sv
module dbs_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff;

  // zero gap behaves as one cycle
  assign eff = (val_i == '0) ? CNT_W'(1) : val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= eff - CNT_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);

  AST_GAP_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0); // R6
  AST_GAP_COUNTS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R6
endmodule

// File: rtl/dbs_seq_ctrl.sv
module dbs_seq_ctrl
  import dbs_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int TMR_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [TMR_W-1:0]  t_rp_i,
  input  logic [TMR_W-1:0]  t_rcd_i,
  input  logic              lk_open_i,
  input  logic [ROW_W-1:0]  lk_row_i,
  input  logic              tmr_done_i,
  output logic              tmr_load_o,
  output logic [TMR_W-1:0]  tmr_val_o,
  output logic              act_o,
  output logic              pre_o,
  output logic              rd_o,
  output logic [BANK_W-1:0] upd_bank_o,
  output logic [ROW_W-1:0]  upd_row_o,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              kind_valid_o,
  output logic [1:0]        kind_o
);
  seq_state_e state_q, state_d;
  kind_e      kind;
  cmd_e       cmd;
  logic       acc;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;

  assign req_ready_o = (state_q == S_IDLE);
  assign acc         = req_valid_i && req_ready_o;

  always_comb begin
    if (!lk_open_i)                kind = KIND_EMPTY;
    else if (lk_row_i == req_row_i) kind = KIND_HIT;
    else                           kind = KIND_CONFLICT;
  end

  assign kind_valid_o = acc;
  assign kind_o       = acc ? kind : KIND_NONE;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (acc) begin
        unique case (kind)
          KIND_HIT:      state_d = S_WRD;
          KIND_EMPTY:    state_d = S_WACT;
          default:       state_d = S_PRE;
        endcase
      end
      S_PRE:  state_d = S_WACT;
      S_WACT: if (tmr_done_i) state_d = S_WRD;
      S_WRD:  if (tmr_done_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      state_q <= state_d;
      if (acc) begin
        bank_q <= req_bank_i;
        row_q  <= req_row_i;
        col_q  <= req_col_i;
      end
    end
  end

  always_comb begin
    cmd = CMD_NOP;
    unique case (state_q)
      S_PRE:   cmd = CMD_PRE;
      S_WACT:  if (tmr_done_i) cmd = CMD_ACT;
      S_WRD:   if (tmr_done_i) cmd = CMD_RD;
      default: cmd = CMD_NOP;
    endcase
  end

  assign pre_o = (cmd == CMD_PRE);
  assign act_o = (cmd == CMD_ACT);
  assign rd_o  = (cmd == CMD_RD);

  // one shared timer: precharge starts the tRP gap, activate the tRCD gap
  assign tmr_load_o = pre_o || act_o;
  assign tmr_val_o  = pre_o ? t_rp_i : t_rcd_i;

  assign upd_bank_o = bank_q;
  assign upd_row_o  = row_q;

  assign cmd_o      = cmd;
  assign cmd_bank_o = (cmd != CMD_NOP) ? bank_q : '0;
  assign cmd_row_o  = act_o ? row_q : '0;
  assign cmd_col_o  = rd_o ? col_q : '0;

  AST_HIT_READ_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && kind == KIND_HIT) |=> cmd_o == CMD_RD); // R3
  AST_EMPTY_ACT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && kind == KIND_EMPTY) |=> cmd_o == CMD_ACT); // R4
  AST_CONFLICT_PRE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && kind == KIND_CONFLICT) |=> cmd_o == CMD_PRE); // R5
  AST_READ_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD) |=> req_ready_o); // R2
  AST_BUSY_NO_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> (!kind_valid_o && kind_o == KIND_NONE)); // R9
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int TMR_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [TMR_W-1:0]  t_rp_i,
  input  logic [TMR_W-1:0]  t_rcd_i,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              kind_valid_o,
  output logic [1:0]        kind_o
);
  logic              lk_open;
  logic [ROW_W-1:0]  lk_row;
  logic              tmr_done, tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              act, pre, rd;
  logic [BANK_W-1:0] upd_bank;
  logic [ROW_W-1:0]  upd_row;

  dbs_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
    .clk_i, .rst_ni,
    .lk_bank_i (req_bank_i),
    .lk_open_o (lk_open),
    .lk_row_o  (lk_row),
    .act_i     (act),
    .pre_i     (pre),
    .rd_i      (rd),
    .upd_bank_i(upd_bank),
    .upd_row_i (upd_row)
  );

  dbs_gap_timer #(.CNT_W(TMR_W)) u_timer (
    .clk_i, .rst_ni,
    .load_i(tmr_load),
    .val_i (tmr_val),
    .done_o(tmr_done)
  );

  dbs_seq_ctrl #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .TMR_W(TMR_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_bank_i, .req_row_i, .req_col_i,
    .t_rp_i, .t_rcd_i,
    .lk_open_i (lk_open),
    .lk_row_i  (lk_row),
    .tmr_done_i(tmr_done),
    .tmr_load_o(tmr_load),
    .tmr_val_o (tmr_val),
    .act_o     (act),
    .pre_o     (pre),
    .rd_o      (rd),
    .upd_bank_o(upd_bank),
    .upd_row_o (upd_row),
    .cmd_o, .cmd_bank_o, .cmd_row_o, .cmd_col_o,
    .kind_valid_o, .kind_o
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (req_ready_o && cmd_o == 2'd0)); // R1
endmodule

// File: tb/sim_dram_bank_seq.sv
module sim_dram_bank_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_bank = '0;
  logic [13:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [3:0]  t_rp = 4'd1;
  logic [3:0]  t_rcd = 4'd1;
  logic [1:0]  cmd;
  logic [2:0]  cmd_bank;
  logic [13:0] cmd_row;
  logic [9:0]  cmd_col;
  logic        kind_valid;
  logic [1:0]  kind;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dram_bank_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .t_rp_i(t_rp), .t_rcd_i(t_rcd),
    .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .kind_valid_o(kind_valid), .kind_o(kind)
  );

  // {bank, row, col, t_rp, t_rcd, expected kind}
  localparam int NV = 11;
  localparam logic [36:0] VECS [NV] = '{
    {3'd0, 14'd5,     10'd1,    4'd3,  4'd2,  2'd2},  // R4 empty
    {3'd0, 14'd5,     10'd2,    4'd3,  4'd2,  2'd1},  // R3 hit
    {3'd0, 14'd9,     10'd3,    4'd2,  4'd4,  2'd3},  // R5 conflict
    {3'd1, 14'd9,     10'd4,    4'd1,  4'd1,  2'd2},  // R4 minimal gap
    {3'd0, 14'd9,     10'd5,    4'd1,  4'd1,  2'd1},  // R8 hit after other bank
    {3'd1, 14'd7,     10'd6,    4'd1,  4'd1,  2'd3},  // R5 minimal gaps
    {3'd7, 14'd16383, 10'd1023, 4'd15, 4'd15, 2'd2},  // R4 max fields/gap
    {3'd7, 14'd0,     10'd0,    4'd15, 4'd15, 2'd3},  // R5 max gaps
    {3'd1, 14'd7,     10'd7,    4'd9,  4'd9,  2'd1},  // R8 hit
    {3'd3, 14'd7,     10'd8,    4'd0,  4'd0,  2'd2},  // R6 zero gap, empty
    {3'd3, 14'd1,     10'd9,    4'd0,  4'd0,  2'd3}   // R6 zero gap, conflict
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(cmd == 2'd0, tag, "cmd idle", cmd, 0);
    chk(cmd_bank == 0 && cmd_row == 0 && cmd_col == 0, tag, "fields zero",
        int'(cmd_bank) + int'(cmd_row) + int'(cmd_col), 0);
  endtask

  task automatic run_req(input logic [2:0] b, input logic [13:0] r, input logic [9:0] c,
                         input logic [3:0] trp, input logic [3:0] trcd,
                         input logic [1:0] ek, input bit busy);
    int ep, ed, len, t_act;
    string tag;
    ep = (trp == 0) ? 1 : int'(trp);
    ed = (trcd == 0) ? 1 : int'(trcd);
    tag = (trp == 0 || trcd == 0) ? "R6" :
          (ek == 2'd1) ? "R3" : (ek == 2'd2) ? "R4" : "R5";
    len   = (ek == 2'd1) ? 1 : (ek == 2'd2) ? 1 + ed : 1 + ep + ed;
    t_act = (ek == 2'd2) ? 1 : 1 + ep;
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c;
    t_rp = trp; t_rcd = trcd;
    #1;
    chk(req_ready == 1'b1, "R2", "ready before accept", req_ready, 1);
    chk(kind_valid == 1'b1 && kind == ek, "R2", "kind on accept", kind, ek);
    @(posedge clk);
    for (int i = 1; i <= len; i++) begin
      int ecmd;
      @(negedge clk);
      if (i == 1) begin
        if (busy) begin
          req_bank = 3'd2; req_row = 14'd1; req_col = 10'd3;
        end else begin
          req_valid = 1'b0;
        end
      end
      #1;
      if (i == len)                         ecmd = 2;
      else if (ek == 2'd3 && i == 1)        ecmd = 3;
      else if (ek != 2'd1 && i == t_act)    ecmd = 1;
      else                                  ecmd = 0;
      chk(int'(cmd) == ecmd, tag, $sformatf("cmd at cycle %0d", i), cmd, ecmd);
      chk(cmd_bank == ((ecmd != 0) ? b : 3'd0), "R7", "bank field", cmd_bank,
          (ecmd != 0) ? b : 0);
      chk(cmd_row == ((ecmd == 1) ? r : 14'd0), "R7", "row field", cmd_row,
          (ecmd == 1) ? r : 0);
      chk(cmd_col == ((ecmd == 2) ? c : 10'd0), "R7", "col field", cmd_col,
          (ecmd == 2) ? c : 0);
      if (busy) begin
        chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
        chk(kind_valid == 1'b0 && kind == 2'd0, "R9", "no kind while busy", kind, 0);
      end else if (i < len) begin
        chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
      end
    end
    @(negedge clk);
    if (busy) req_valid = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R2", "ready after read", req_ready, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk_idle("R1");
    chk(kind_valid == 1'b0, "R1", "no kind in reset", kind_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk_idle("R1");

    for (int v = 0; v < NV; v++) begin
      logic [36:0] e;
      e = VECS[v];
      run_req(e[36:34], e[33:20], e[19:10], e[9:6], e[5:2], e[1:0], 1'b0);
    end

    // R8: bank 0 keeps row 9 open across traffic to banks 1, 3, 7
    run_req(3'd0, 14'd9, 10'd11, 4'd2, 4'd2, 2'd1, 1'b0);
    // R8: bank 5 untouched so far stays idle
    run_req(3'd5, 14'd9, 10'd12, 4'd2, 4'd3, 2'd2, 1'b0);

    // R9: request held during a conflict sequence is not taken
    run_req(3'd0, 14'd100, 10'd13, 4'd3, 4'd2, 2'd3, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk_idle("R9");
    end
    // bank 2 was never opened by the ignored request
    run_req(3'd2, 14'd1, 10'd3, 4'd1, 4'd1, 2'd2, 1'b0);

    // R1: reset mid-sequence clears every open row
    @(negedge clk);
    req_valid = 1'b1; req_bank = 3'd0; req_row = 14'd5; req_col = 10'd0;
    t_rp = 4'd5; t_rcd = 4'd5;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    run_req(3'd0, 14'd100, 10'd14, 4'd2, 4'd2, 2'd2, 1'b0);
    run_req(3'd2, 14'd1, 10'd15, 4'd2, 4'd2, 2'd2, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule